// File: doc/BRIEF.md
# Byte-Enabled ECC-Protected SRAM Array

A synchronous static memory of 16-bit words. Each word is stored as a 21-bit Hamming codeword: 16 data bits and 5 check bits. Individual byte lanes can be written and read through active-low byte enables. The array is selected either by one active-low chip enable, or by that enable together with a second, active-high enable. On every read, a single flipped bit anywhere in the accessed codeword is corrected before the data leaves the block, and an error flag goes high for that read. The corrected value is not written back, so the fault stays in storage until the word is next written.

The shared data bus is split into a write-data input and a registered read-data output. Two per-lane valid outputs take the place of tri-state control. A registered standby output marks the cycles in which no access is enabled. Byte power-down forces standby whenever both byte enables are off, whatever the chip enables are doing. A half-width mode treats the array as twice as many 8-bit locations, and the lowest address bit picks the lane. A test port flips one stored bit so that correction can be exercised.

Top module: `ecc_sram`

## Requirements
- R1: The block is selected when `cs1_n`=0 and either `dual_en`=0 or `cs2`=1. When it is not selected, no write occurs, both valids and `err` are 0 on the next cycle, and `cs2` has no effect while `dual_en`=0.
- R2: A selected cycle with `we_n`=0 writes the addressed word. `ub_n`=0 updates bits 15:8 and `lb_n`=0 updates bits 7:0. A lane whose enable is high keeps its old value.
- R3: A selected cycle with `we_n`=1, `oe_n`=0 and at least one byte enable low is a read. On the next cycle, `rdata` carries each enabled lane, each disabled lane reads 0, `rvalid_hi` = !`ub_n` and `rvalid_lo` = !`lb_n`.
- R4: On the cycle after any non-read cycle (deselected, `oe_n`=1, `we_n`=0, or both byte enables high), both valids, `err` and `rdata` are 0.
- R5: `standby` is registered. It is 0 on the cycle after a selected cycle with at least one byte enable low, and 1 otherwise, including when both byte enables are high and the chip enables select the block.
- R6: If one of the 21 codeword bits of the accessed word is flipped, a read returns the original data and raises `err` on the same cycle as the valids.
- R7: A read does not repair storage. Repeated reads of a faulty word, in either width mode, keep raising `err`.
- R8: Any write to a word, full or partial, re-encodes the whole word. The faulty bit is cleared and the unwritten lane keeps its corrected value.
- R9: With `byte_mode`=1, the word index is `addr[ADDR_W:1]` and `addr[0]` picks the lane (1 = bits 15:8). Writes take `wdata[7:0]`. Reads return the byte on `rdata[7:0]` with `rvalid_lo`=1, `rvalid_hi`=0 and `rdata[15:8]`=0. Either byte enable being low enables the access. With `byte_mode`=0, `addr[ADDR_W]` is ignored.
- R10: While `rst` is high, `rdata`, both valids and `err` are 0 and `standby` is 1.
- R11: `inj_en`=1 flips stored bit `inj_bit` (codeword index 0..20) of word `inj_addr`. Values of 21 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs1_n | input | 1 | Active-low chip enable |
| cs2 | input | 1 | Active-high second chip enable, used when dual_en=1 |
| dual_en | input | 1 | Selects dual chip-enable decoding |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| ub_n | input | 1 | Active-low upper byte enable (bits 15:8) |
| lb_n | input | 1 | Active-low lower byte enable (bits 7:0) |
| byte_mode | input | 1 | Half-width, double-depth mode |
| addr | input | ADDR_W+1 | Address; the top bit is used only in byte mode |
| wdata | input | 16 | Write data |
| inj_en | input | 1 | Test: flip one stored bit |
| inj_addr | input | ADDR_W | Test: word to corrupt |
| inj_bit | input | 5 | Test: codeword bit index |
| rdata | output | 16 | Registered read data |
| rvalid_hi | output | 1 | Upper lane of rdata is driven |
| rvalid_lo | output | 1 | Lower lane of rdata is driven |
| err | output | 1 | Read corrected a single-bit error |
| standby | output | 1 | Registered power-down indication |

## Verification
Some properties are checked on every cycle. A valid output is only ever preceded by a genuine read cycle. A disabled lane always reads zero. The error flag never appears without a valid. Deselection or byte power-down is always followed by standby. Byte mode never drives the upper lane. Other behaviour can only be shown by bench scenarios that keep a shadow model: that data survives partial writes, that each of the 21 codeword positions is corrected, that a fault persists across reads until a write clears it, and that writes on deselected cycles leave storage untouched.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DW   = 16;
  localparam int NB   = DW / 8;
  localparam int PW   = 5;
  localparam int CW   = DW + PW;
  localparam int SW   = 5;

  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CW-1:0] hamm_enc(logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic x;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= CW; p++) begin
      if (!is_pow2(p)) begin
        c[p-1] = d[j];
        j++;
      end
    end
    for (int k = 0; k < PW; k++) begin
      x = 1'b0;
      for (int p = 1; p <= CW; p++)
        if (((p >> k) & 1) == 1) x = x ^ c[p-1];
      c[(1 << k) - 1] = x;
    end
    return c;
  endfunction

  function automatic logic [PW-1:0] hamm_syn(logic [CW-1:0] c);
    logic [PW-1:0] s;
    s = '0;
    for (int k = 0; k < PW; k++)
      for (int p = 1; p <= CW; p++)
        if (((p >> k) & 1) == 1) s[k] = s[k] ^ c[p-1];
    return s;
  endfunction

  function automatic logic [DW-1:0] hamm_fix(logic [CW-1:0] c, logic [PW-1:0] s);
    logic [CW-1:0] cc;
    logic [DW-1:0] d;
    int si;
    int j;
    cc = c;
    si = int'(s);
    if (si >= 1 && si <= CW) cc[si-1] = ~cc[si-1];
    d = '0;
    j = 0;
    for (int p = 1; p <= CW; p++) begin
      if (!is_pow2(p)) begin
        d[j] = cc[p-1];
        j++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl import ecc_sram_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              dual_en,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              byte_mode,
  input  logic [ADDR_W:0]   addr,
  output logic              wr,
  output logic              rd,
  output logic [ADDR_W-1:0] idx,
  output logic [NB-1:0]     mask,
  output logic              lane,
  output logic              idle_nxt
);
  logic sel, act;

  always_comb begin
    sel      = !cs1_n && (!dual_en || cs2);
    act      = sel && !(ub_n && lb_n);
    wr       = act && !we_n;
    rd       = act && we_n && !oe_n;
    idle_nxt = !act;
    lane     = byte_mode && addr[0];
    if (byte_mode) begin
      idx  = addr[ADDR_W:1];
      mask = addr[0] ? 2'b10 : 2'b01;
    end else begin
      idx  = addr[ADDR_W-1:0];
      mask = {!ub_n, !lb_n};
    end
  end
endmodule

// File: rtl/ecc_sram_array.sv
module ecc_sram_array import ecc_sram_pkg::*; #(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [ADDR_W-1:0] idx,
  input  logic [NB-1:0]     mask,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     fixed,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [SW-1:0]     inj_bit,
  output logic [CW-1:0]     rd_cw
);
  localparam logic [SW-1:0] CW_L = SW'(CW);

  logic [CW-1:0] mem [DEPTH];
  logic [DW-1:0] merged;

  assign rd_cw = mem[idx];

  always_comb begin
    for (int b = 0; b < NB; b++)
      merged[b*8 +: 8] = mask[b] ? wdata[b*8 +: 8] : fixed[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (wr)
      mem[idx] <= hamm_enc(merged);
    else if (inj_en && inj_bit < CW_L)
      mem[inj_addr][inj_bit] <= ~mem[inj_addr][inj_bit];
  end
endmodule

// File: rtl/ecc_sram_rdport.sv
module ecc_sram_rdport import ecc_sram_pkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic [NB-1:0] mask,
  input  logic          byte_mode,
  input  logic          lane,
  input  logic [DW-1:0] data,
  input  logic          syn_nz,
  input  logic          idle_nxt,
  output logic [DW-1:0] rdata,
  output logic          rvalid_hi,
  output logic          rvalid_lo,
  output logic          err,
  output logic          standby
);
  logic [DW-1:0] lane_data;

  always_comb begin
    if (byte_mode) begin
      lane_data = {8'h00, lane ? data[15:8] : data[7:0]};
    end else begin
      for (int b = 0; b < NB; b++)
        lane_data[b*8 +: 8] = mask[b] ? data[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rvalid_hi <= 1'b0;
      rvalid_lo <= 1'b0;
      err       <= 1'b0;
      standby   <= 1'b1;
    end else begin
      standby <= idle_nxt;
      if (rd) begin
        rdata     <= lane_data;
        rvalid_hi <= !byte_mode && mask[1];
        rvalid_lo <= byte_mode || mask[0];
        err       <= syn_nz;
      end else begin
        rdata     <= '0;
        rvalid_hi <= 1'b0;
        rvalid_lo <= 1'b0;
        err       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecc_sram.sv
module ecc_sram import ecc_sram_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              dual_en,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              byte_mode,
  input  logic [ADDR_W:0]   addr,
  input  logic [DW-1:0]     wdata,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [SW-1:0]     inj_bit,
  output logic [DW-1:0]     rdata,
  output logic              rvalid_hi,
  output logic              rvalid_lo,
  output logic              err,
  output logic              standby
);
  logic              wr, rd, lane, idle_nxt;
  logic [ADDR_W-1:0] idx;
  logic [NB-1:0]     mask;
  logic [CW-1:0]     rd_cw;
  logic [PW-1:0]     syn;
  logic [DW-1:0]     fixed;
  logic [DW-1:0]     wsteer;

  ecc_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .cs1_n(cs1_n), .cs2(cs2), .dual_en(dual_en), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .byte_mode(byte_mode), .addr(addr),
    .wr(wr), .rd(rd), .idx(idx), .mask(mask), .lane(lane), .idle_nxt(idle_nxt)
  );

  assign syn    = hamm_syn(rd_cw);
  assign fixed  = hamm_fix(rd_cw, syn);
  assign wsteer = byte_mode ? {wdata[7:0], wdata[7:0]} : wdata;

  ecc_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .wr(wr), .idx(idx), .mask(mask), .wdata(wsteer), .fixed(fixed),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit), .rd_cw(rd_cw)
  );

  ecc_sram_rdport u_rdport (
    .clk(clk), .rst(rst), .rd(rd), .mask(mask), .byte_mode(byte_mode),
    .lane(lane), .data(fixed), .syn_nz(syn != '0), .idle_nxt(idle_nxt),
    .rdata(rdata), .rvalid_hi(rvalid_hi), .rvalid_lo(rvalid_lo),
    .err(err), .standby(standby)
  );
endmodule

// File: rtl/ecc_sram_chk.sv
module ecc_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            cs1_n,
  input logic            cs2,
  input logic            dual_en,
  input logic            we_n,
  input logic            oe_n,
  input logic            ub_n,
  input logic            lb_n,
  input logic            byte_mode,
  input logic [15:0]     rdata,
  input logic            rvalid_hi,
  input logic            rvalid_lo,
  input logic            err,
  input logic            standby
);
  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    (rvalid_hi || rvalid_lo) |->
      $past(!cs1_n && (!dual_en || cs2) && we_n && !oe_n && !(ub_n && lb_n)));

  // R3
  hi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rvalid_hi |-> rdata[15:8] == 8'h00);

  // R3
  lo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rvalid_lo |-> rdata[7:0] == 8'h00);

  // R6
  err_qual_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (rvalid_hi || rvalid_lo));

  // R5
  bpd_standby_chk: assert property (@(posedge clk) disable iff (rst)
    (ub_n && lb_n) |=> standby);

  // R1
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (cs1_n || (dual_en && !cs2)) |=> (standby && !rvalid_hi && !rvalid_lo && !err));

  // R9
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid_hi |-> !$past(byte_mode));
endmodule

bind ecc_sram ecc_sram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ecc_sram_tb.sv
module ecc_sram_tb;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst;
  logic cs1_n, cs2, dual_en, we_n, oe_n, ub_n, lb_n, byte_mode, inj_en;
  logic [ADDR_W:0]   addr;
  logic [15:0]       wdata;
  logic [ADDR_W-1:0] inj_addr;
  logic [4:0]        inj_bit;
  logic [15:0]       rdata;
  logic rvalid_hi, rvalid_lo, err, standby;

  logic [15:0] sh [DEPTH];
  bit          bad [DEPTH];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_sram #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .dual_en(dual_en),
    .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .byte_mode(byte_mode),
    .addr(addr), .wdata(wdata), .inj_en(inj_en), .inj_addr(inj_addr),
    .inj_bit(inj_bit), .rdata(rdata), .rvalid_hi(rvalid_hi),
    .rvalid_lo(rvalid_lo), .err(err), .standby(standby)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs1_n = 1; cs2 = 0; dual_en = 0; we_n = 1; oe_n = 1; ub_n = 1; lb_n = 1;
    byte_mode = 0; addr = '0; wdata = '0; inj_en = 0; inj_addr = '0; inj_bit = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] exp_word(int i, bit u, bit l);
    return {u ? sh[i][15:8] : 8'h00, l ? sh[i][7:0] : 8'h00};
  endfunction

  task automatic quiet(string tag, bit exp_sb);
    chk(!rvalid_hi && !rvalid_lo && !err && rdata == 16'h0, tag,
        {rvalid_hi, rvalid_lo, err, rdata}, 32'h0);
    chk(standby == exp_sb, {tag, " standby R5"}, standby, exp_sb);
  endtask

  task automatic wr_word(int i, logic [15:0] d, bit u, bit l);
    idle(); cs1_n = 0; we_n = 0; ub_n = !u; lb_n = !l;
    addr = {1'($urandom), 6'(i)}; wdata = d;
    step();
    if (u) sh[i][15:8] = d[15:8];
    if (l) sh[i][7:0] = d[7:0];
    if (u || l) bad[i] = 0;
    quiet("R4 write cycle", !(u || l));
  endtask

  task automatic rd_word(int i, bit u, bit l, string tag);
    logic [15:0] e;
    idle(); cs1_n = 0; oe_n = 0; ub_n = !u; lb_n = !l;
    addr = {1'($urandom), 6'(i)};
    if ($urandom % 2 == 1) begin dual_en = 1; cs2 = 1; end
    step();
    e = exp_word(i, u, l);
    chk(rdata == e, {tag, " R2 R3 R9 data"}, rdata, e);
    chk(rvalid_hi == u && rvalid_lo == l, {tag, " R3 valids"}, {rvalid_hi, rvalid_lo}, {u, l});
    chk(err == (bad[i] && (u || l)), {tag, " R6 R7 err"}, err, bad[i] && (u || l));
    chk(standby == !(u || l), {tag, " R5 standby"}, standby, !(u || l));
  endtask

  task automatic rd_byte(int ba, string tag);
    logic [15:0] e;
    int i;
    i = ba >> 1;
    idle(); cs1_n = 0; oe_n = 0; byte_mode = 1; addr = 7'(ba);
    if ($urandom % 2 == 1) lb_n = 0; else ub_n = 0;
    step();
    e = {8'h00, (ba % 2 == 1) ? sh[i][15:8] : sh[i][7:0]};
    chk(rdata == e, {tag, " R9 byte data"}, rdata, e);
    chk(!rvalid_hi && rvalid_lo, {tag, " R9 byte valids"}, {rvalid_hi, rvalid_lo}, 2'b01);
    chk(err == bad[i], {tag, " R6 R7 byte err"}, err, bad[i]);
  endtask

  task automatic wr_byte(int ba, logic [7:0] d);
    int i;
    i = ba >> 1;
    idle(); cs1_n = 0; we_n = 0; byte_mode = 1; addr = 7'(ba);
    lb_n = 0; wdata = {8'($urandom), d};
    step();
    if (ba % 2 == 1) sh[i][15:8] = d; else sh[i][7:0] = d;
    bad[i] = 0;
    quiet("R9 byte write", 0);
  endtask

  task automatic inject(int i, int b);
    idle(); inj_en = 1; inj_addr = 6'(i); inj_bit = 5'(b);
    step();
    if (b < 21) bad[i] = 1;
  endtask

  task automatic desel(int i, int mode, bit do_wr);
    idle();
    case (mode)
      0: begin cs1_n = 1; end
      1: begin cs1_n = 0; dual_en = 1; cs2 = 0; end
      default: begin cs1_n = 1; dual_en = 1; cs2 = 1; end
    endcase
    ub_n = 0; lb_n = 0; addr = 7'(i); wdata = 16'($urandom);
    if (do_wr) we_n = 0; else oe_n = 0;
    step();
    quiet("R1 deselected", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    quiet("R10 reset", 1);
    rst = 0;

    for (int i = 0; i < DEPTH; i++) wr_word(i, 16'($urandom), 1, 1);
    for (int i = 0; i < DEPTH; i++) bad[i] = 0;

    rd_word(5, 1, 1, "full read");
    wr_word(5, 16'hA55A, 1, 0);
    rd_word(5, 1, 1, "R2 upper only");
    wr_word(5, 16'h3CC3, 0, 1);
    rd_word(5, 1, 1, "R2 lower only");
    rd_word(5, 1, 0, "R3 upper lane read");
    rd_word(5, 0, 1, "R3 lower lane read");

    // R6 R7: single data bit, repeated reads
    inject(7, 2);
    rd_word(7, 1, 1, "R6 data bit");
    rd_word(7, 1, 1, "R7 repeat");
    rd_byte(15, "R7 byte mode");
    // R8: partial write clears the fault and keeps the upper byte
    wr_word(7, 16'h00EE, 0, 1);
    rd_word(7, 1, 1, "R8 after partial write");

    // R6: every codeword position
    for (int b = 0; b < 21; b++) begin
      inject(10, b);
      rd_word(10, 1, 1, "R6 position sweep");
      wr_word(10, 16'($urandom), 1, 1);
    end

    // R11: out-of-range bit index
    inject(11, 25);
    inject(11, 31);
    rd_word(11, 1, 1, "R11 no flip");

    // R1: deselected writes do nothing
    for (int m = 0; m < 3; m++) desel(12, m, 1);
    for (int m = 0; m < 3; m++) desel(12, m, 0);
    rd_word(12, 1, 1, "R1 unchanged");
    // R1: cs2 ignored in single-enable mode
    idle(); cs1_n = 0; cs2 = 0; we_n = 0; ub_n = 0; lb_n = 0; addr = 7'd13; wdata = 16'hBEEF;
    step();
    sh[13] = 16'hBEEF; bad[13] = 0;
    rd_word(13, 1, 1, "R1 single enable");

    // R4: output enable high
    idle(); cs1_n = 0; ub_n = 0; lb_n = 0; addr = 7'd13;
    step();
    quiet("R4 oe high", 0);
    // R5: byte power-down while selected
    idle(); cs1_n = 0; oe_n = 0; addr = 7'd13;
    step();
    quiet("R5 byte power-down", 1);

    // R9: byte writes into both lanes
    wr_byte(40, 8'h12);
    wr_byte(41, 8'h34);
    rd_word(20, 1, 1, "R9 lanes merged");
    rd_byte(41, "R9 upper lane");

    for (int n = 0; n < 400; n++) begin
      int op, i;
      op = int'($urandom % 6);
      i  = int'($urandom % DEPTH);
      case (op)
        0: wr_word(i, 16'($urandom), 1'($urandom), 1'($urandom));
        1: rd_word(i, 1'($urandom), 1'($urandom), "rand read");
        2: if (!bad[i]) inject(i, int'($urandom % 21)); else rd_word(i, 1, 1, "rand faulty read");
        3: rd_byte(int'($urandom % (2 * DEPTH)), "rand byte read");
        4: wr_byte(int'($urandom % (2 * DEPTH)), 8'($urandom));
        default: desel(i, int'($urandom % 3), 1'($urandom));
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule